// File: doc/BRIEF.md
# Rapid Bit Exchange Timer

This block runs the prover side of the timed phase of a distance-bounding exchange. After a start pulse it latches a local random challenge word and launches one challenge bit per round, least significant bit first. It waits for the matching one-bit reply and counts the clock cycles from the launch to the reply. The largest of these counts is kept as the worst round trip. Each round's challenge and reply bits go out as a pair on a transcript stream, so the interleaved record (challenge 1, reply 1, challenge 2, reply 2, ...) can be collected outside the block. The record is twice the length of the challenge word.

When the last round finishes, the block takes a processing allowance off the worst round-trip count, flooring the result at zero, and compares it with a proximity limit given in cycles. It then raises a one-cycle done pulse with the verdict. At a 10 MHz timing clock one count is 100 ns, which is roughly 15 m of one-way range. A programmable reply timeout ends the exchange early with a failing verdict. The default challenge length is 1024 bits, so the transcript is 2048 bits.

Top module: `rbx_timer`

## Requirements
- R1: A start pulse is taken only while the block is idle. A start pulse, or a change of `nonce_i`, during an exchange has no effect on that exchange's challenge bits, timing or verdict.
- R2: Each round raises `chal_valid_o` for exactly one cycle, with `chal_bit_o` equal to bit i of the latched challenge word (round 0 uses bit 0). The first launch is in the cycle after the accepted start, and each later launch is in the cycle after the previous reply cycle.
- R3: `resp_valid_i` is sampled only while a reply is awaited. A reply in a launch cycle or while idle is ignored.
- R4: A round's trip count is the number of cycles from its launch cycle to its reply cycle. A reply in the cycle right after the launch counts 1.
- R5: `max_rtt_o` is cleared to 0 when a start is accepted. It then holds the largest trip count of the completed rounds, and it keeps its value after the exchange ends.
- R6: The trip counter stops at 2^CNT_W-1 and does not wrap.
- R7: For each accepted reply, `tr_valid_o` is high for one cycle in the next cycle, with `tr_pair_o[0]` the challenge bit and `tr_pair_o[1]` the reply bit, in round order.
- R8: After the final reply, `done_o` pulses for one cycle two cycles after the reply cycle. In that cycle `pass_o` is 1 exactly when (max - alpha, or 0 if alpha >= max) <= threshold. `pass_o` is 0 in all other cycles.
- R9: With a nonzero timeout T, if no reply is present by the T-th cycle after a launch, `done_o` pulses with `pass_o` = 0 in the next cycle and no further challenge is sent. A reply in that T-th cycle is still accepted. A timeout of 0 disables this abort.
- R10: After reset, every output is 0.
- R11: `busy_o` is high from the cycle after an accepted start up to the cycle before `done_o`, and it is low while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, honoured when idle |
| nonce_i | input | N_BITS | Local random challenge word |
| alpha_i | input | CNT_W | Processing allowance in cycles |
| thresh_i | input | CNT_W | Proximity limit in cycles |
| timeout_i | input | CNT_W | Reply timeout in cycles, 0 disables it |
| resp_valid_i | input | 1 | Reply present |
| resp_bit_i | input | 1 | Reply bit |
| chal_valid_o | output | 1 | Challenge launch strobe |
| chal_bit_o | output | 1 | Challenge bit |
| tr_valid_o | output | 1 | Transcript pair strobe |
| tr_pair_o | output | 2 | {reply bit, challenge bit} |
| done_o | output | 1 | End-of-exchange pulse |
| pass_o | output | 1 | Proximity verdict, valid with done_o |
| max_rtt_o | output | CNT_W | Worst round-trip count |
| busy_o | output | 1 | Exchange in progress |

## Verification
Two events can fall in the same cycle: a reply arriving and the timeout expiring. The bench sets the timeout equal to the reply delay, so the reply lands in exactly the cycle in which the counter reaches the limit. The rules say the reply must win. A cycle-level model checks that the round completes, that its count equals the limit, and that the verdict still follows the threshold. A second run leaves a round unanswered, and the bench checks that the abort then comes one cycle later with no new launch.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DECIDE = 2'd3
  } rbx_state_t;
endpackage

// File: rtl/rbx_sat_counter.sv
// Round-trip counter: loads 1 in the launch cycle and counts up until it holds at all-ones.
module rbx_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_one,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)
      cnt_o <= '0;
    else if (load_one)
      cnt_o <= W'(1);
    else if (inc && cnt_o != TOP)
      cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/rbx_chal_src.sv
// Holds the challenge word, shifts it one bit per finished round and tracks the round index.
module rbx_chal_src #(
  parameter int N_BITS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [N_BITS-1:0] nonce_i,
  input  logic              shift,
  output logic              bit_o,
  output logic              last_o
);
  localparam int RW = (N_BITS > 1) ? $clog2(N_BITS) : 1;
  localparam logic [RW-1:0] LAST_IDX = RW'(N_BITS - 1);

  logic [N_BITS-1:0] word_q;
  logic [RW-1:0]     idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      word_q <= nonce_i;
      idx_q  <= '0;
    end else if (shift) begin
      word_q <= word_q >> 1;
      idx_q  <= idx_q + RW'(1);
    end
  end

  assign bit_o  = word_q[0];
  assign last_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/rbx_max_judge.sv
// Keeps the worst trip count and forms the proximity verdict from it.
module rbx_max_judge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         upd,
  input  logic [W-1:0] sample_i,
  input  logic [W-1:0] alpha_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] max_o,
  output logic         near_o
);
  logic [W-1:0] net;

  always_ff @(posedge clk) begin
    if (rst || clr)
      max_o <= '0;
    else if (upd && sample_i > max_o)
      max_o <= sample_i;
  end

  always_comb begin
    net    = (max_o > alpha_i) ? (max_o - alpha_i) : '0;
    near_o = (net <= limit_i);
  end
endmodule

// File: rtl/rbx_timer.sv
module rbx_timer #(
  parameter int N_BITS = 1024,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [N_BITS-1:0] nonce_i,
  input  logic [CNT_W-1:0]  alpha_i,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic [CNT_W-1:0]  timeout_i,
  input  logic              resp_valid_i,
  input  logic              resp_bit_i,
  output logic              chal_valid_o,
  output logic              chal_bit_o,
  output logic              tr_valid_o,
  output logic [1:0]        tr_pair_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [CNT_W-1:0]  max_rtt_o,
  output logic              busy_o
);
  import rbx_pkg::*;

  rbx_state_t       state_q, state_d;
  logic [CNT_W-1:0] rtt_cnt;
  logic             cur_bit, last_round, near;
  logic             accept, reply, expired;

  always_comb begin
    accept  = (state_q == ST_IDLE) && start_i;
    reply   = (state_q == ST_WAIT) && resp_valid_i;
    expired = (state_q == ST_WAIT) && !resp_valid_i &&
              (timeout_i != '0) && (rtt_cnt >= timeout_i);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_LAUNCH;
      ST_LAUNCH: state_d = ST_WAIT;
      ST_WAIT: begin
        if (reply)        state_d = last_round ? ST_DECIDE : ST_LAUNCH;
        else if (expired) state_d = ST_IDLE;
      end
      ST_DECIDE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  rbx_sat_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_one (state_q == ST_LAUNCH),
    .inc      ((state_q == ST_WAIT) && !resp_valid_i),
    .cnt_o    (rtt_cnt)
  );

  rbx_chal_src #(.N_BITS(N_BITS)) u_src (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .nonce_i (nonce_i),
    .shift   (reply),
    .bit_o   (cur_bit),
    .last_o  (last_round)
  );

  rbx_max_judge #(.W(CNT_W)) u_judge (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .upd      (reply),
    .sample_i (rtt_cnt),
    .alpha_i  (alpha_i),
    .limit_i  (thresh_i),
    .max_o    (max_rtt_o),
    .near_o   (near)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      chal_valid_o <= 1'b0;
      tr_valid_o   <= 1'b0;
      tr_pair_o    <= 2'b00;
      done_o       <= 1'b0;
      pass_o       <= 1'b0;
    end else begin
      state_q      <= state_d;
      chal_valid_o <= accept || (reply && !last_round);
      tr_valid_o   <= reply;
      if (reply) tr_pair_o <= {resp_bit_i, cur_bit};
      done_o       <= expired || (state_q == ST_DECIDE);
      pass_o       <= (state_q == ST_DECIDE) && near;
    end
  end

  assign chal_bit_o = cur_bit;
  assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/rbx_timer_chk.sv
module rbx_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             chal_valid_o,
  input logic             tr_valid_o,
  input logic             done_o,
  input logic             pass_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] max_rtt_o
);
  // R2
  chal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    chal_valid_o |=> !chal_valid_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  pass_gated_chk: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> done_o);

  // R5
  max_mono_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (max_rtt_o >= $past(max_rtt_o)));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R7
  tr_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    tr_valid_o |-> busy_o);
endmodule

bind rbx_timer rbx_timer_chk #(.CNT_W(CNT_W)) u_rbx_chk (
  .clk          (clk),
  .rst          (rst),
  .chal_valid_o (chal_valid_o),
  .tr_valid_o   (tr_valid_o),
  .done_o       (done_o),
  .pass_o       (pass_o),
  .busy_o       (busy_o),
  .max_rtt_o    (max_rtt_o)
);

// File: tb/test_rbx_timer.sv
module test_rbx_timer;
  localparam int NB = 8;
  localparam int CW = 8;
  localparam int MAXC = 255;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, resp_valid_i = 0, resp_bit_i = 0;
  logic [NB-1:0] nonce_i = '0;
  logic [CW-1:0] alpha_i = '0, thresh_i = '0, timeout_i = '0;
  logic chal_valid_o, chal_bit_o, tr_valid_o, done_o, pass_o, busy_o;
  logic [1:0] tr_pair_o;
  logic [CW-1:0] max_rtt_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rbx_timer #(.N_BITS(NB), .CNT_W(CW)) i_rbx_timer (
    .clk(clk), .rst(rst), .start_i(start_i), .nonce_i(nonce_i),
    .alpha_i(alpha_i), .thresh_i(thresh_i), .timeout_i(timeout_i),
    .resp_valid_i(resp_valid_i), .resp_bit_i(resp_bit_i),
    .chal_valid_o(chal_valid_o), .chal_bit_o(chal_bit_o),
    .tr_valid_o(tr_valid_o), .tr_pair_o(tr_pair_o), .done_o(done_o),
    .pass_o(pass_o), .max_rtt_o(max_rtt_o), .busy_o(busy_o));

  task automatic cmp(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 idle, 1 launch, 2 awaiting reply, 3 verdict
  int mode = 0, m_idx = 0, m_cnt = 0;
  logic [NB-1:0] m_word = '0;
  logic e_cv = 0, e_cb = 0, e_trv = 0, e_done = 0, e_pass = 0, e_busy = 0;
  logic [1:0] e_trp = '0;
  int e_max = 0;

  always @(posedge clk) begin
    if (rst) begin
      mode = 0; e_cv = 0; e_trv = 0; e_done = 0; e_pass = 0; e_max = 0; e_busy = 0;
    end else begin
      e_cv = 0; e_trv = 0; e_done = 0; e_pass = 0;
      case (mode)
        0: if (start_i) begin
             m_word = nonce_i; m_idx = 0; e_max = 0; mode = 1;
             e_cv = 1; e_cb = nonce_i[0];
           end
        1: begin mode = 2; m_cnt = 1; end
        2: if (resp_valid_i) begin
             if (m_cnt > e_max) e_max = m_cnt;
             e_trv = 1; e_trp = {resp_bit_i, m_word[m_idx]};
             if (m_idx == NB - 1) mode = 3;
             else begin m_idx++; mode = 1; e_cv = 1; e_cb = m_word[m_idx]; end
           end else if (timeout_i != 0 && m_cnt >= int'(timeout_i)) begin
             e_done = 1; mode = 0;
           end else if (m_cnt < MAXC) m_cnt++;
        default: begin
          e_done = 1;
          e_pass = (((e_max > int'(alpha_i)) ? e_max - int'(alpha_i) : 0) <= int'(thresh_i));
          mode = 0;
        end
      endcase
      e_busy = (mode != 0);
    end
  end

  always @(negedge clk) if (!rst && !finished) begin
    cmp(chal_valid_o === e_cv, "R2 chal_valid", chal_valid_o, e_cv);
    if (e_cv) cmp(chal_bit_o === e_cb, "R2 chal_bit", chal_bit_o, e_cb);
    cmp(tr_valid_o === e_trv, "R7 tr_valid", tr_valid_o, e_trv);
    if (e_trv) cmp(tr_pair_o === e_trp, "R7 tr_pair", tr_pair_o, e_trp);
    cmp(done_o === e_done, "R8/R9 done", done_o, e_done);
    cmp(pass_o === e_pass, "R8 pass", pass_o, e_pass);
    cmp(max_rtt_o === CW'(e_max), "R5 max_rtt", max_rtt_o, e_max);
    cmp(busy_o === e_busy, "R11 busy", busy_o, e_busy);
  end

  // dl[i] = reply delay of round i in cycles; 0 leaves the round unanswered
  task automatic exchange(input logic [NB-1:0] nonce, input int dl[8], input logic [NB-1:0] rb,
                          input int spur, input int tmo, input int al, input int th);
    timeout_i = CW'(tmo); alpha_i = CW'(al); thresh_i = CW'(th); nonce_i = nonce;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    for (int i = 0; i < NB; i++) begin
      int g = 0;
      while (!chal_valid_o && g < 400) begin @(negedge clk); g++; end
      if (i == spur) begin // R1 / R3: reply and start offered in the launch cycle
        resp_valid_i = 1; resp_bit_i = 1; start_i = 1; nonce_i = ~nonce;
      end
      if (dl[i] == 0) begin
        @(negedge clk); resp_valid_i = 0; start_i = 0;
        return;
      end
      repeat (dl[i]) begin @(negedge clk); resp_valid_i = 0; start_i = 0; end
      resp_valid_i = 1; resp_bit_i = rb[i];
      @(negedge clk); resp_valid_i = 0;
    end
  endtask

  task automatic wait_done(input logic ep, input int em, input string tag);
    int g = 0;
    while (!done_o && g < 2000) begin @(negedge clk); g++; end
    cmp(done_o === 1'b1, {tag, " done seen"}, done_o, 1);
    cmp(pass_o === ep, {tag, " verdict"}, pass_o, ep);
    cmp(max_rtt_o === CW'(em), {tag, " worst trip"}, max_rtt_o, em);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    cmp({chal_valid_o, tr_valid_o, done_o, pass_o, busy_o} === 5'b0, "R10 flags", 0, 0);
    cmp(max_rtt_o === '0, "R10 max", max_rtt_o, 0);

    // R4 mixed delays, pass
    exchange(8'hA5, '{1,3,2,5,4,1,2,3}, 8'h3C, -1, 50, 2, 10);
    wait_done(1, 5, "R4 R8 near");
    // R8 worst trip too long
    exchange(8'h5A, '{4,20,3,2,7,1,1,6}, 8'hF0, -1, 50, 2, 10);
    wait_done(0, 20, "R8 far");
    // R8 allowance above max floors at zero, timeout disabled
    exchange(8'hFF, '{2,2,5,1,3,4,2,2}, 8'h00, -1, 0, 30, 0);
    wait_done(1, 5, "R8 floor");
    // R8 boundary: net equals limit
    exchange(8'h33, '{3,12,4,4,4,4,4,1}, 8'hAA, -1, 50, 2, 10);
    wait_done(1, 12, "R8 equal");
    // R8 boundary: net one over limit
    exchange(8'hC3, '{13,1,1,1,1,1,1,1}, 8'h0F, -1, 50, 2, 10);
    wait_done(0, 13, "R8 over");
    // R1 R3 start and reply offered in a launch cycle are ignored
    exchange(8'h96, '{2,3,4,2,2,2,2,2}, 8'h55, 2, 50, 0, 4);
    wait_done(1, 4, "R1 R3 busy start");
    // R9 reply in the same cycle the timeout is reached wins
    exchange(8'h69, '{10,1,1,1,1,1,1,1}, 8'h81, -1, 10, 0, 20);
    wait_done(1, 10, "R9 edge reply");
    // R3 replies while idle leave the worst trip alone
    resp_valid_i = 1; resp_bit_i = 1;
    repeat (5) @(negedge clk);
    resp_valid_i = 0;
    cmp(max_rtt_o === CW'(10), "R3 idle reply", max_rtt_o, 10);
    // R9 unanswered round aborts
    exchange(8'h0F, '{2,3,0,1,1,1,1,1}, 8'h00, -1, 10, 0, 20);
    wait_done(0, 3, "R9 abort");
    begin
      int seen = 0;
      repeat (20) begin @(negedge clk); if (chal_valid_o) seen++; end
      cmp(seen == 0, "R9 no launch after abort", seen, 0);
    end
    // R6 counter holds at its top value
    exchange(8'hE7, '{300,1,1,1,1,1,1,1}, 8'h12, -1, 0, 0, 255);
    wait_done(1, 255, "R6 saturation");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule